// File: doc/BRIEF.md
# Flip-Flop Parallel-to-Serial Transmitter

This block turns a parallel word into a serial bitstream. It uses only ordinary flip-flops and counters. The bit clock runs at RATIO times the word rate, and the word width equals RATIO. RATIO may be 2, 4 or 8.

A word clock marks when the next word is valid. That clock is either supplied on an input or produced inside the block by dividing the bit clock. The word clock is sampled in the bit-clock domain. Each rising edge copies the parallel input into a holding register.

A boundary counter runs on the bit clock, and a comparator on that counter loads the shift register. The counter is released only by the first word-clock rise after reset. The serial bit passes through a final output flop before leaving the block. A forwarded clock output carries either the bit clock or the word clock, chosen by a parameter.

Top module: `ser_tx`

## Requirements
- R1: Reset is synchronous and active high. While it is applied, and at the first edge where it is seen, `ser_o` becomes 0 and all sequencing state clears.
- R2: The holding register takes `data_i` only at a bit-clock edge where the word clock is high and was low at the previous edge. Values that `data_i` holds at any other edge are ignored.
- R3: Until the first word-clock rise after reset, the boundary counter stays idle and no load occurs. During that time `ser_o` stays 0 whatever `data_i` does.
- R4: The first load happens RATIO bit-clock edges after the first capture. Later loads follow every RATIO edges. The MSB of each new word follows the LSB of the previous word with no idle cycle between them.
- R5: Each loaded word is sent most-significant bit first, one bit per bit-clock cycle.
- R6: Take a word captured at edge c. Its bit i appears on `ser_o` just after edge c+RATIO+1+(RATIO-1-i).
- R7: With EXT_WORD_CLK=0, the word clock comes from a divide-by-RATIO counter. That clock is high for the first RATIO/2 cycles of each period, and its first rise follows the first edge after reset. Captures therefore fall on edges 2, 2+RATIO, 2+2·RATIO and so on after reset release. In this mode `word_clk_i` is ignored.
- R8: With FWD_SEL=FWD_BIT, `clk_fwd_o` follows `clk_i`. With FWD_SEL=FWD_WORD, it follows the word clock in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_i | input | 1 | Synchronous active-high reset |
| word_clk_i | input | 1 | External word clock, synchronous to `clk_i`; used when EXT_WORD_CLK=1 |
| data_i | input | RATIO | Parallel word |
| ser_o | output | 1 | Registered serial bit |
| clk_fwd_o | output | 1 | Forwarded bit clock or word clock |

## Verification
The bench builds two instances side by side:
- **RATIO=8, internal divider, bit clock forwarded.** All 256 byte values are streamed through this instance back to back. This covers every bit pattern, including the word-to-word seams, under the divider timing. An input word clock that toggles every cycle shows that the external clock is ignored in this mode.
- **RATIO=4, external word clock, word clock forwarded.** The word clock starts late, so the idle period before the first rise can be observed. The data bus carries a wrong value at every edge except the capture edge, which exposes any capture at the wrong moment.

A reset in the middle of the run, followed by a long period with no word clock, checks that the block returns to idle.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    typedef enum logic {
        FWD_BIT  = 1'b0,
        FWD_WORD = 1'b1
    } fwd_sel_e;

endpackage

// File: rtl/ser_word_clk.sv
module ser_word_clk #(
    parameter int RATIO        = 8,
    parameter bit EXT_WORD_CLK = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic word_clk_i,
    output logic word_clk_o,
    output logic word_rise_o
);

    logic prev_d, prev_q;

    generate
        if (EXT_WORD_CLK) begin : g_ext
            assign word_clk_o = word_clk_i;
        end else begin : g_div
            localparam int DIV_W = (RATIO > 2) ? $clog2(RATIO) : 1;
            localparam logic [DIV_W-1:0] LAST = DIV_W'(RATIO - 1);
            localparam logic [DIV_W-1:0] HALF = DIV_W'(RATIO / 2);

            logic [DIV_W-1:0] div_d, div_q;
            logic             wgen_d, wgen_q;

            always_comb begin
                div_d  = (div_q == LAST) ? '0 : div_q + 1'b1;
                wgen_d = (div_d < HALF);
            end

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    div_q  <= LAST;
                    wgen_q <= 1'b0;
                end else begin
                    div_q  <= div_d;
                    wgen_q <= wgen_d;
                end
            end

            assign word_clk_o = wgen_q;
        end
    endgenerate

    always_comb begin
        prev_d      = word_clk_o;
        word_rise_o = word_clk_o & ~prev_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= prev_d;
    end

endmodule

// File: rtl/ser_bound_ctr.sv
module ser_bound_ctr #(
    parameter int RATIO = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic word_rise_i,
    output logic started_o,
    output logic load_o
);

    localparam int CNT_W = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);

    typedef struct packed {
        logic             started;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.started = st_q.started | word_rise_i;
        if (st_q.started) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign started_o = st_q.started;
    assign load_o    = st_q.started && (st_q.cnt == LAST);

endmodule

// File: rtl/ser_piso.sv
module ser_piso #(
    parameter int RATIO = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             capture_i,
    input  logic             load_i,
    input  logic [RATIO-1:0] data_i,
    output logic             ser_o
);

    typedef struct packed {
        logic [RATIO-1:0] hold;
        logic [RATIO-1:0] shift;
        logic             dout;
    } piso_t;

    piso_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        if (capture_i) st_d.hold = data_i;
        if (load_i)    st_d.shift = st_q.hold;
        else           st_d.shift = {st_q.shift[RATIO-2:0], 1'b0};
        st_d.dout = st_q.shift[RATIO-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign ser_o = st_q.dout;

endmodule

// File: rtl/ser_tx.sv
module ser_tx
    import ser_tx_pkg::*;
#(
    parameter int       RATIO        = 8,
    parameter bit       EXT_WORD_CLK = 1'b1,
    parameter fwd_sel_e FWD_SEL      = FWD_BIT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             word_clk_i,
    input  logic [RATIO-1:0] data_i,
    output logic             ser_o,
    output logic             clk_fwd_o
);

    logic word_clk;
    logic word_rise;
    logic started;
    logic load;

    ser_word_clk #(
        .RATIO        (RATIO),
        .EXT_WORD_CLK (EXT_WORD_CLK)
    ) i_word_clk (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .word_clk_i  (word_clk_i),
        .word_clk_o  (word_clk),
        .word_rise_o (word_rise)
    );

    ser_bound_ctr #(
        .RATIO (RATIO)
    ) i_bound_ctr (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .word_rise_i (word_rise),
        .started_o   (started),
        .load_o      (load)
    );

    ser_piso #(
        .RATIO (RATIO)
    ) i_piso (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .capture_i (word_rise),
        .load_i    (load),
        .data_i    (data_i),
        .ser_o     (ser_o)
    );

    generate
        if (FWD_SEL == FWD_WORD) begin : g_fwd_word
            assign clk_fwd_o = word_clk;
        end else begin : g_fwd_bit
            assign clk_fwd_o = clk_i;
        end
    endgenerate

endmodule

// File: rtl/ser_tx_chk.sv
module ser_tx_chk #(
    parameter int RATIO = 8
) (
    input logic clk_i,
    input logic rst_i,
    input logic word_rise,
    input logic load,
    input logic started,
    input logic ser_o
);

    logic [7:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (load) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != 8'hFF) begin
            gap_q  <= gap_q + 8'd1;
        end
    end

    // R3: sequencing starts only on a word-clock rise and then stays on
    p_start_needs_rise_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!started && !word_rise) |=> !started);
    p_started_sticky_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        started |=> started);
    p_no_early_load_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !started |-> !load);
    p_quiet_before_start_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !started |=> !ser_o);

    // R4: loads are exactly RATIO cycles apart
    p_load_period_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (load && seen_q) |-> (gap_q == 8'(RATIO - 1)));
    p_load_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        load |=> !load);

endmodule

bind ser_tx ser_tx_chk #(.RATIO(RATIO)) i_ser_tx_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .word_rise (word_rise),
    .load      (load),
    .started   (started),
    .ser_o     (ser_o)
);

// File: tb/test_ser_tx.sv
module test_ser_tx;
    import ser_tx_pkg::*;

    localparam int RA      = 8;
    localparam int RB      = 4;
    localparam int FIRST_B = 20;
    localparam int NEND    = 2070;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst;
    logic          wclk_a, wclk_b;
    logic [RA-1:0] data_a;
    logic [RB-1:0] data_b;
    logic          ser_a, ser_b, fwd_a, fwd_b;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    ser_tx #(.RATIO(RA), .EXT_WORD_CLK(1'b0), .FWD_SEL(FWD_BIT)) i_ser_tx (
        .clk_i(clk), .rst_i(rst), .word_clk_i(wclk_a), .data_i(data_a),
        .ser_o(ser_a), .clk_fwd_o(fwd_a));

    ser_tx #(.RATIO(RB), .EXT_WORD_CLK(1'b1), .FWD_SEL(FWD_WORD)) i_ser_tx_b (
        .clk_i(clk), .rst_i(rst), .word_clk_i(wclk_b), .data_i(data_b),
        .ser_o(ser_b), .clk_fwd_o(fwd_b));

    function automatic logic [RA-1:0] word_a(int k);
        return RA'((k * 37 + 5) % 256);
    endfunction

    function automatic logic [RB-1:0] word_b(int k);
        return RB'(k % 16);
    endfunction

    task automatic check(logic got, logic exp, string req, string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [RA-1:0] wa;
        logic [RB-1:0] wb;
        rst    = 1'b1;
        wclk_a = 1'b0;
        wclk_b = 1'b0;
        data_a = '0;
        data_b = '0;
        repeat (3) @(posedge clk);
        #5;
        check(ser_a, 1'b0, "R1", "reset ser_o A");
        check(ser_b, 1'b0, "R1", "reset ser_o B");
        rst = 1'b0;

        for (int n = 1; n <= NEND; n++) begin
            @(posedge clk);
            #5;
            // instance A: internal divider, captures at edges 2+8k
            if (n < RA + 3) begin
                check(ser_a, 1'b0, "R3", "A idle before first load");
            end else begin
                int m, k, j;
                string req;
                m  = n - (RA + 3);
                k  = m / RA;
                j  = m % RA;
                wa = word_a(k);
                req = (k == 0 && j == 0) ? "R7" : (j == 0) ? "R6" :
                      (j == RA - 1) ? "R4" : "R5";
                check(ser_a, wa[RA-1-j], req, $sformatf("A word %0d bit %0d", k, RA-1-j));
            end
            // instance B: external word clock, captures at edges FIRST_B+4k
            if (n < FIRST_B + RB + 1) begin
                check(ser_b, 1'b0, "R3", "B idle before first word clock");
            end else begin
                int m, k, j;
                string req;
                m  = n - (FIRST_B + RB + 1);
                k  = m / RB;
                j  = m % RB;
                wb = word_b(k);
                req = (j == 0) ? "R6" : (j == 1) ? "R2" : (j == RB - 1) ? "R4" : "R5";
                check(ser_b, wb[RB-1-j], req, $sformatf("B word %0d bit %0d", k, RB-1-j));
            end
            check(fwd_a, 1'b1, "R8", "A forwards bit clock high");
            check(fwd_b, wclk_b, "R8", "B forwards word clock");

            // next stimulus
            wclk_a = ((n % 2) == 1);
            if ((n - 1) % RA == 0)      data_a = word_a((n - 1) / RA);
            else if ((n - 2) % RA == 0) data_a = ~word_a((n - 2) / RA);

            if (n < FIRST_B - 1) begin
                wclk_b = 1'b0;
                data_b = RB'(n * 5 + 3);
            end else begin
                wclk_b = ((n - (FIRST_B - 1)) % RB) < (RB / 2);
                if ((n - (FIRST_B - 1)) % RB == 0)
                    data_b = word_b((n - (FIRST_B - 1)) / RB);
                else if (n >= FIRST_B && (n - FIRST_B) % RB == 0)
                    data_b = ~word_b((n - FIRST_B) / RB);
            end
            #10;
            check(fwd_a, 1'b0, "R8", "A forwards bit clock low");
        end

        // reset in mid-stream
        @(posedge clk);
        #5;
        rst    = 1'b1;
        wclk_b = 1'b0;
        @(posedge clk);
        #5;
        check(ser_a, 1'b0, "R1", "mid-run reset A");
        check(ser_b, 1'b0, "R1", "mid-run reset B");
        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            data_b = RB'(i * 7 + 1);
            @(posedge clk);
            #5;
            check(ser_b, 1'b0, "R3", "B quiet without word clock after reset");
        end
        finish_run();
    end

endmodule